// File: doc/BRIEF.md
# Core Isolation Boundary Chain

This block surrounds a core with boundary cells on its functional inputs and outputs. The cells are joined into one serial register chain, so a tester can reach the core through a few wrapper pins. It can load stimulus into the core, read back the core's responses, and do the same for the logic around the core, without using the core's functional ports.

Each boundary cell has two registers. A shift stage takes part in capture and shifting. A separate update stage holds the value that the cell drives, so driven values stay steady while the chain moves. A two-bit mode input selects one of three modes:

- **Transparent:** both buses pass straight through.
- **Inward test:** input cells feed the core from their update stages, and the external inputs have no effect.
- **Outward test:** output cells feed the surrounding logic from their update stages, and the core's outputs have no effect.

A port whose functional flip-flop already serves as its boundary cell can be marked through a per-bit reuse mask. Such a port gets no dedicated cell.

Top module: `core_wrap_chain`

## Requirements
- R1: In mode 2'b00, core_in equals pi_in and po_out equals core_out in the same cycle, with no register stage in either path.
- R2: The chain holds one cell per non-reused input bit, ordered from least to most significant, followed by one cell per non-reused output bit, ordered from least to most significant. wsi enters input cell 0 on each shift cycle, each cell takes its predecessor's value, and wso shows the shift stage of the last cell in the chain.
- R3: In mode 2'b01, each non-reused core_in bit is driven from its cell's update stage, and changes on pi_in have no effect on those bits.
- R4: On a capture cycle, input cells load the value of pi_in and output cells load the value of core_out into their shift stages.
- R5: In mode 2'b10, each non-reused po_out bit is driven from its cell's update stage, and changes on core_out have no effect on those bits. In this mode, core_in follows pi_in.
- R6: An update stage loads its shift stage only on a cycle where update_en is high and both capture_en and shift_en are low. At all other times, including while the chain shifts, it holds its value.
- R7: Control priority is capture, then shift, then update. When capture_en and shift_en are both high, the cells capture. Update never happens in the same cycle as a capture or a shift.
- R8: A bit set in a reuse mask has no cell. That port passes straight through in every mode and is left out of the chain.
- R9: An asynchronous low rst_n clears every shift stage and every update stage to zero at once.
- R10: Mode 2'b11 behaves as mode 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock for all boundary cells |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 transparent, 01 inward test, 10 outward test, 11 transparent |
| wsi | input | 1 | Serial data into the chain |
| wso | output | 1 | Serial data out of the chain |
| shift_en | input | 1 | Shift the chain one position |
| capture_en | input | 1 | Load the shift stages from the observed sides |
| update_en | input | 1 | Copy the shift stages into the update stages |
| pi_in | input | N_IN | Functional inputs from the surrounding logic |
| core_in | output | N_IN | Inputs delivered to the core |
| core_out | input | N_OUT | Outputs produced by the core |
| po_out | output | N_OUT | Outputs delivered to the surrounding logic |

## Verification
Several properties are checked on every clock inside the cells and the top:

- the capture-over-shift priority;
- that shifting moves each cell's predecessor value;
- that update stages hold unless a clean update arrives;
- that the driven side stays stable in the test modes while no update is pending;
- that the transparent paths match.

Some behaviour can only be shown by the bench scenarios:

- the full chain order and length under a reuse mask, checked by whole-chain load and unload;
- the values captured from both sides;
- that the reused bit passes through in every mode;
- the asynchronous clear taking effect in the middle of a cycle.

// File: rtl/wrap_pkg.sv
package wrap_pkg;

  typedef enum logic [1:0] {
    MODE_FUNC   = 2'b00,
    MODE_INTEST = 2'b01,
    MODE_EXTEST = 2'b10,
    MODE_SPARE  = 2'b11
  } wrap_mode_e;

  // Next value of a shift stage: capture wins over shift, otherwise hold.
  function automatic logic cell_next(input logic cap, input logic shf,
                                     input logic src, input logic ser,
                                     input logic cur);
    if (cap)      return src;
    else if (shf) return ser;
    else          return cur;
  endfunction

  // A clean update needs update high with capture and shift both low.
  function automatic logic upd_fire(input logic cap, input logic shf,
                                    input logic upd);
    return upd & ~cap & ~shf;
  endfunction

endpackage

// File: rtl/wrap_cell.sv
module wrap_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic test_sel,
  input  logic src,
  input  logic ser_in,
  output logic sh_q,
  output logic drv
);

  logic up_q;
  logic upd_go;
  logic sh_nxt;

  assign upd_go = wrap_pkg::upd_fire(cap_en, shift_en, upd_en);
  assign sh_nxt = wrap_pkg::cell_next(cap_en, shift_en, src, ser_in, sh_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= 1'b0;
      up_q <= 1'b0;
    end else begin
      sh_q <= sh_nxt;
      if (upd_go) up_q <= sh_q;
    end
  end

  assign drv = test_sel ? up_q : src;

  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (sh_q == $past(src))); // R7

  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cap_en) |=> (sh_q == $past(ser_in))); // R2

  AST_UPD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en || shift_en || !upd_en) |=> $stable(up_q)); // R6

endmodule

// File: rtl/wrap_segment.sv
module wrap_segment #(
  parameter int         W     = 4,
  parameter logic [W-1:0] REUSE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         shift_en,
  input  logic         upd_en,
  input  logic         test_sel,
  input  logic [W-1:0] src,
  input  logic         ser_in,
  output logic [W-1:0] drv,
  output logic         ser_out
);

  logic [W:0] link;
  assign link[0] = ser_in;

  for (genvar k = 0; k < W; k++) begin : g_bit
    if (REUSE[k]) begin : g_reused
      assign drv[k]    = src[k];
      assign link[k+1] = link[k];
    end else begin : g_cell
      logic sh_bit;
      wrap_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .upd_en   (upd_en),
        .test_sel (test_sel),
        .src      (src[k]),
        .ser_in   (link[k]),
        .sh_q     (sh_bit),
        .drv      (drv[k])
      );
      assign link[k+1] = sh_bit;
    end
  end

  assign ser_out = link[W];

endmodule

// File: rtl/core_wrap_chain.sv
module core_wrap_chain #(
  parameter int             N_IN      = 4,
  parameter int             N_OUT     = 4,
  parameter logic [N_IN-1:0]  IN_REUSE  = '0,
  parameter logic [N_OUT-1:0] OUT_REUSE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             wsi,
  output logic             wso,
  input  logic             shift_en,
  input  logic             capture_en,
  input  logic             update_en,
  input  logic [N_IN-1:0]  pi_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] po_out
);

  import wrap_pkg::*;

  logic intest_sel;
  logic extest_sel;
  logic mid_link;
  logic transparent;

  assign intest_sel  = (mode == MODE_INTEST);
  assign extest_sel  = (mode == MODE_EXTEST);
  assign transparent = (mode == MODE_FUNC) || (mode == MODE_SPARE);

  wrap_segment #(.W(N_IN), .REUSE(IN_REUSE)) u_in_seg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (capture_en),
    .shift_en (shift_en),
    .upd_en   (update_en),
    .test_sel (intest_sel),
    .src      (pi_in),
    .ser_in   (wsi),
    .drv      (core_in),
    .ser_out  (mid_link)
  );

  wrap_segment #(.W(N_OUT), .REUSE(OUT_REUSE)) u_out_seg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (capture_en),
    .shift_en (shift_en),
    .upd_en   (update_en),
    .test_sel (extest_sel),
    .src      (core_out),
    .ser_in   (mid_link),
    .drv      (po_out),
    .ser_out  (wso)
  );

  AST_FUNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    transparent |-> (core_in == pi_in && po_out == core_out)); // R1

  AST_INTEST_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (intest_sel && !update_en) |=> (!intest_sel || $stable(core_in & ~IN_REUSE))); // R3

  AST_EXTEST_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (extest_sel && !update_en) |=> (!extest_sel || $stable(po_out & ~OUT_REUSE))); // R5

  AST_EXTEST_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    extest_sel |-> (core_in == pi_in)); // R5

endmodule

// File: tb/core_wrap_chain_tb_top.sv
module core_wrap_chain_tb_top;

  localparam int NI  = 4;
  localparam int NO  = 4;
  localparam logic [NI-1:0] RM = 4'b0010;
  localparam int NDI = 3;
  localparam int L   = NDI + NO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic wsi = 1'b0, shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0;
  logic wso;
  logic [NI-1:0] pi_in = '0, core_in;
  logic [NO-1:0] core_out = '0, po_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  core_wrap_chain #(.N_IN(NI), .N_OUT(NO), .IN_REUSE(RM), .OUT_REUSE('0)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wsi(wsi), .wso(wso),
    .shift_en(shift_en), .capture_en(capture_en), .update_en(update_en),
    .pi_in(pi_in), .core_in(core_in), .core_out(core_out), .po_out(po_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Pack the dedicated input bits of a bus into chain order.
  function automatic logic [NDI-1:0] pack_in(input logic [NI-1:0] v);
    logic [NDI-1:0] r = '0;
    int j = 0;
    for (int k = 0; k < NI; k++) if (!RM[k]) begin r[j] = v[k]; j++; end
    return r;
  endfunction

  // Expected core_in in inward test: cells for dedicated bits, pass for reused.
  function automatic logic [NI-1:0] expand_in(input logic [NDI-1:0] c, input logic [NI-1:0] p);
    logic [NI-1:0] r = '0;
    int j = 0;
    for (int k = 0; k < NI; k++) begin
      if (RM[k]) r[k] = p[k];
      else begin r[k] = c[j]; j++; end
    end
    return r;
  endfunction

  task automatic shift_chain(input logic [L-1:0] vin, output logic [L-1:0] vout);
    for (int i = L - 1; i >= 0; i--) begin
      @(negedge clk);
      vout[i]  = wso;
      wsi      = vin[i];
      shift_en = 1'b1;
    end
    @(negedge clk);
    shift_en = 1'b0;
    wsi      = 1'b0;
  endtask

  task automatic pulse(input logic c, input logic s, input logic u);
    @(negedge clk);
    capture_en = c; shift_en = s; update_en = u;
    @(negedge clk);
    capture_en = 1'b0; shift_en = 1'b0; update_en = 1'b0;
  endtask

  initial begin
    logic [L-1:0] got;
    logic [NI-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(wso == 1'b0, "R9 reset wso", wso, 0);
    shift_chain('0, got);
    chk(got == '0, "R9 reset chain zero", got, 0);

    // R1 and R10: transparent sweep with mode 00 and 11
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        mode = (b[0]) ? 2'b11 : 2'b00;
        pi_in = a[NI-1:0]; core_out = b[NO-1:0];
        #1;
        chk(core_in == a[NI-1:0] && po_out == b[NO-1:0], "R1/R10 transparent",
            {core_in, po_out}, {a[3:0], b[3:0]});
      end
    end

    // R4 and R2: capture from both sides, then unload in chain order
    mode = 2'b01;
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      pi_in = a[NI-1:0]; core_out = ~a[NO-1:0];
      pulse(1'b1, 1'b0, 1'b0);
      shift_chain('0, got);
      chk(got == {~a[NO-1:0], pack_in(a[NI-1:0])}, "R4/R2 capture unload",
          got, {~a[NO-1:0], pack_in(a[NI-1:0])});
    end

    // R2: shifted-in pattern comes back unchanged after a full pass
    shift_chain(7'b1011001, got);
    shift_chain('0, got);
    chk(got == 7'b1011001, "R2 chain round trip", got, 7'b1011001);

    // R3 and R8: inward drive, pi_in ignored on dedicated bits
    mode = 2'b01;
    for (int pat = 0; pat < 8; pat++) begin
      shift_chain({4'b0, pat[NDI-1:0]}, got);
      pulse(1'b0, 1'b0, 1'b1);
      for (int p = 0; p < 16; p++) begin
        @(negedge clk);
        pi_in = p[NI-1:0];
        #1;
        chk(core_in == expand_in(pat[NDI-1:0], p[NI-1:0]), "R3/R8 inward drive",
            core_in, expand_in(pat[NDI-1:0], p[NI-1:0]));
      end
    end

    // R6: shifting without update leaves driven values unchanged
    shift_chain({4'b0, 3'b101}, got);
    pulse(1'b0, 1'b0, 1'b1);
    pi_in = 4'b0000;
    held = expand_in(3'b101, 4'b0000);
    shift_chain({4'b0, 3'b010}, got);
    #1;
    chk(core_in == held, "R6 hold during shift", core_in, held);
    pulse(1'b0, 1'b0, 1'b1);
    #1;
    chk(core_in == expand_in(3'b010, 4'b0000), "R6 update applies", core_in,
        expand_in(3'b010, 4'b0000));

    // R7: update with shift or capture does not update
    shift_chain({4'b0, 3'b111}, got);
    pulse(1'b0, 1'b1, 1'b1);
    #1;
    chk(core_in == expand_in(3'b010, 4'b0000), "R7 update blocked by shift", core_in,
        expand_in(3'b010, 4'b0000));
    pulse(1'b1, 1'b0, 1'b1);
    #1;
    chk(core_in == expand_in(3'b010, 4'b0000), "R7 update blocked by capture", core_in,
        expand_in(3'b010, 4'b0000));

    // R7: capture wins over shift
    shift_chain('1, got);
    pi_in = 4'b0000; core_out = 4'b0000;
    @(negedge clk);
    wsi = 1'b1;
    pulse(1'b1, 1'b1, 1'b0);
    wsi = 1'b0;
    shift_chain('0, got);
    chk(got == '0, "R7 capture over shift", got, 0);

    // R5: outward drive, core_out ignored, core_in follows pi_in
    mode = 2'b10;
    for (int op = 0; op < 16; op += 5) begin
      shift_chain({op[NO-1:0], 3'b000}, got);
      pulse(1'b0, 1'b0, 1'b1);
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        core_out = c[NO-1:0]; pi_in = ~c[NI-1:0];
        #1;
        chk(po_out == op[NO-1:0] && core_in == ~c[NI-1:0], "R5 outward drive",
            {po_out, core_in}, {op[3:0], ~c[3:0]});
      end
    end

    // R9: asynchronous clear mid-cycle
    mode = 2'b01;
    shift_chain('1, got);
    pulse(1'b0, 1'b0, 1'b1);
    pi_in = 4'b0000;
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk(core_in == 4'b0000 && wso == 1'b0, "R9 async clear", {core_in, 3'b0, wso}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule